// File: doc/BRIEF.md
# Processor Status Register with Flag Arbitration

This block holds the eight-bit status word of a small accumulator-style microcontroller core. Three kinds of update meet in one register. The ALU can update its result flags (zero, digit carry, carry). Ordinary data-bus writes land here when the register is the destination of an instruction. Power-management events (watchdog clear, entry to sleep, watchdog expiry) move the two power-state bits. A synchronous, active-high power-on input returns the whole word to its initial value.

The bit layout, from bit 7 down to bit 0, is: indirect bank select, direct bank select high, direct bank select low, time-out flag, power-down flag, zero, digit carry, carry. C and DC are stored exactly as the ALU supplies them. For subtraction they carry borrow meaning, where 1 means no borrow. DC is the carry out of bit 3.

A state machine holds the two power-state bits. It has four states. PWR_RUN is time-out 1, power-down 1. PWR_DOZE is 1/0. PWR_TRIP_RUN is 0/1. PWR_TRIP_DOZE is 0/0. Its transitions are:
- A watchdog clear ("wake") goes to PWR_RUN.
- A sleep ("doze") goes to PWR_DOZE.
- A watchdog expiry ("trip") goes from PWR_RUN to PWR_TRIP_RUN and from PWR_DOZE to PWR_TRIP_DOZE. A tripped state stays where it is.
- Power-on goes to PWR_RUN.

The block also forms two nine-bit data-memory addresses from the bank bits. One is for direct accesses (two bank bits plus a seven-bit offset). The other is for indirect accesses (one bank bit plus an eight-bit pointer).

Top module: `proc_status_reg`

## Requirements
- R1: On the clock edge where `por` is high, the register becomes 8'b0001_1000: all bank bits 0, time-out and power-down 1, and zero, digit carry and carry all 0.
- R2: A bus write (`bus_we`=1) stores `bus_wdata[7:5]` into the bank bits. If no flag update enable is high in that cycle, it also stores `bus_wdata[2:0]` into Z, DC and C. Bits 4 and 3 never take bus data.
- R3: With no bus write, each flag whose update enable is high (`upd_z`, `upd_dc`, `upd_c`) takes its value input. The other flags keep their old values.
- R4: If a bus write and at least one flag update enable are high in the same cycle, bus data is discarded for all three flag positions. Updated flags take their value inputs and the remaining flags hold. A clear-to-zero write with only the Z update at value 1 therefore leaves 000u u1uu.
- R5: A watchdog clear event (`ev_wdt_clr`) sets both time-out and power-down to 1.
- R6: A sleep event (`ev_sleep`) sets time-out to 1 and power-down to 0.
- R7: A watchdog expiry (`ev_wdt_trip`) clears time-out to 0 and leaves power-down unchanged.
- R8: When several events come in one cycle, expiry wins over sleep, and sleep wins over clear.
- R9: A power event and a bus write in the same cycle both take effect. The event sets bits 4 and 3, and the bus write still updates bits 7:5 (and the flags, as R2 and R4 allow).
- R10: `dir_addr` equals {bit 6, bit 5, `dir_offset`} of the current register value, combinationally.
- R11: `ind_addr` equals {bit 7, `ind_ptr`} of the current register value, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| por | input | 1 | Synchronous active-high power-on reset |
| bus_we | input | 1 | Register is the destination of a bus write this cycle |
| bus_wdata | input | 8 | Bus write data |
| upd_z | input | 1 | ALU updates zero flag |
| val_z | input | 1 | New zero flag value |
| upd_dc | input | 1 | ALU updates digit carry flag |
| val_dc | input | 1 | New digit carry value |
| upd_c | input | 1 | ALU updates carry flag |
| val_c | input | 1 | New carry value |
| ev_wdt_clr | input | 1 | Watchdog clear event |
| ev_sleep | input | 1 | Sleep entry event |
| ev_wdt_trip | input | 1 | Watchdog expiry event |
| dir_offset | input | OFF_W | Direct access offset within a bank |
| ind_ptr | input | PTR_W | Indirect access pointer |
| status_q | output | 8 | Registered status word |
| dir_addr | output | OFF_W+2 | Banked direct data-memory address |
| ind_addr | output | PTR_W+1 | Banked indirect data-memory address |

## Verification
The bench builds the block with OFF_W=7 and PTR_W=8. At these widths every direct offset can be swept under all eight bank-bit patterns, and so can every indirect pointer. Several further sweeps are small enough to cover completely:
- all 256 bus data words,
- every combination of flag update enables and values, both with and without a bus write,
- every ordered pair of event combinations, which visits all four power states and every transition between them.

// File: rtl/stat_pkg.sv
package stat_pkg;

    localparam int STAT_W = 8;
    localparam int FLAG_N = 3;

    localparam int B_IRP = 7;
    localparam int B_RP1 = 6;
    localparam int B_RP0 = 5;
    localparam int B_TO  = 4;
    localparam int B_PD  = 3;
    localparam int B_Z   = 2;
    localparam int B_DC  = 1;
    localparam int B_C   = 0;

    localparam int BANK_N = B_IRP - B_RP0 + 1;

    // Encoding is {time-out, power-down}
    typedef enum logic [1:0] {
        PWR_RUN       = 2'b11,
        PWR_DOZE      = 2'b10,
        PWR_TRIP_RUN  = 2'b01,
        PWR_TRIP_DOZE = 2'b00
    } pwr_state_e;

endpackage

// File: rtl/stat_power_fsm.sv
module stat_power_fsm
    import stat_pkg::*;
(
    input  logic clk,
    input  logic por,
    input  logic ev_clr,
    input  logic ev_sleep,
    input  logic ev_trip,
    output logic to_o,
    output logic pd_o
);

    pwr_state_e st_q;
    pwr_state_e st_d;

    // Next state: expiry beats sleep, sleep beats clear
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PWR_RUN: begin
                if (ev_trip)       st_d = PWR_TRIP_RUN;
                else if (ev_sleep) st_d = PWR_DOZE;
                else               st_d = PWR_RUN;
            end
            PWR_DOZE: begin
                if (ev_trip)       st_d = PWR_TRIP_DOZE;
                else if (ev_sleep) st_d = PWR_DOZE;
                else if (ev_clr)   st_d = PWR_RUN;
            end
            PWR_TRIP_RUN: begin
                if (ev_trip)       st_d = PWR_TRIP_RUN;
                else if (ev_sleep) st_d = PWR_DOZE;
                else if (ev_clr)   st_d = PWR_RUN;
            end
            PWR_TRIP_DOZE: begin
                if (ev_trip)       st_d = PWR_TRIP_DOZE;
                else if (ev_sleep) st_d = PWR_DOZE;
                else if (ev_clr)   st_d = PWR_RUN;
            end
            default: st_d = PWR_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (por) st_q <= PWR_RUN;
        else     st_q <= st_d;
    end

    // Outputs decoded from state
    always_comb begin
        unique case (st_q)
            PWR_RUN:       begin to_o = 1'b1; pd_o = 1'b1; end
            PWR_DOZE:      begin to_o = 1'b1; pd_o = 1'b0; end
            PWR_TRIP_RUN:  begin to_o = 1'b0; pd_o = 1'b1; end
            PWR_TRIP_DOZE: begin to_o = 1'b0; pd_o = 1'b0; end
            default:       begin to_o = 1'b1; pd_o = 1'b1; end
        endcase
    end

endmodule

// File: rtl/stat_flag_merge.sv
module stat_flag_merge
    import stat_pkg::*;
(
    input  logic              clk,
    input  logic              por,
    input  logic              bus_we,
    input  logic [FLAG_N-1:0] bus_flags,
    input  logic [FLAG_N-1:0] upd,
    input  logic [FLAG_N-1:0] val,
    output logic [FLAG_N-1:0] flags_q
);

    logic any_upd;
    logic bus_take;

    assign any_upd  = |upd;
    // Any ALU flag update masks the bus for all flag positions
    assign bus_take = bus_we && !any_upd;

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (por)           flags_q[i] <= 1'b0;
            else if (upd[i])   flags_q[i] <= val[i];
            else if (bus_take) flags_q[i] <= bus_flags[i];
        end
    end

endmodule

// File: rtl/stat_bank_reg.sv
module stat_bank_reg
    import stat_pkg::*;
(
    input  logic              clk,
    input  logic              por,
    input  logic              bus_we,
    input  logic [BANK_N-1:0] bus_bank,
    output logic [BANK_N-1:0] bank_q
);

    always_ff @(posedge clk) begin
        if (por)         bank_q <= '0;
        else if (bus_we) bank_q <= bus_bank;
    end

endmodule

// File: rtl/stat_bank_addr.sv
module stat_bank_addr #(
    parameter int OFF_W = 7,
    parameter int PTR_W = 8,
    localparam int DIR_AW = OFF_W + 2,
    localparam int IND_AW = PTR_W + 1
) (
    input  logic              irp,
    input  logic [1:0]        rp,
    input  logic [OFF_W-1:0]  dir_offset,
    input  logic [PTR_W-1:0]  ind_ptr,
    output logic [DIR_AW-1:0] dir_addr,
    output logic [IND_AW-1:0] ind_addr
);

    assign dir_addr = {rp, dir_offset};
    assign ind_addr = {irp, ind_ptr};

endmodule

// File: rtl/proc_status_reg.sv
module proc_status_reg
    import stat_pkg::*;
#(
    parameter int OFF_W = 7,
    parameter int PTR_W = 8,
    localparam int DIR_AW = OFF_W + 2,
    localparam int IND_AW = PTR_W + 1
) (
    input  logic              clk,
    input  logic              por,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    input  logic              upd_z,
    input  logic              val_z,
    input  logic              upd_dc,
    input  logic              val_dc,
    input  logic              upd_c,
    input  logic              val_c,
    input  logic              ev_wdt_clr,
    input  logic              ev_sleep,
    input  logic              ev_wdt_trip,
    input  logic [OFF_W-1:0]  dir_offset,
    input  logic [PTR_W-1:0]  ind_ptr,
    output logic [7:0]        status_q,
    output logic [DIR_AW-1:0] dir_addr,
    output logic [IND_AW-1:0] ind_addr
);

    logic [BANK_N-1:0] bank_q;
    logic [FLAG_N-1:0] flags_q;
    logic              to_q;
    logic              pd_q;
    logic              unused_pwr_bits;

    // Power-state positions are read-only from the bus
    assign unused_pwr_bits = ^bus_wdata[B_TO:B_PD];

    stat_bank_reg u_bank (
        .clk      (clk),
        .por      (por),
        .bus_we   (bus_we),
        .bus_bank (bus_wdata[B_IRP:B_RP0]),
        .bank_q   (bank_q)
    );

    stat_flag_merge u_flags (
        .clk       (clk),
        .por       (por),
        .bus_we    (bus_we),
        .bus_flags (bus_wdata[B_Z:B_C]),
        .upd       ({upd_z, upd_dc, upd_c}),
        .val       ({val_z, val_dc, val_c}),
        .flags_q   (flags_q)
    );

    stat_power_fsm u_pwr (
        .clk      (clk),
        .por      (por),
        .ev_clr   (ev_wdt_clr),
        .ev_sleep (ev_sleep),
        .ev_trip  (ev_wdt_trip),
        .to_o     (to_q),
        .pd_o     (pd_q)
    );

    assign status_q = {bank_q, to_q, pd_q, flags_q};

    stat_bank_addr #(
        .OFF_W (OFF_W),
        .PTR_W (PTR_W)
    ) u_addr (
        .irp        (status_q[B_IRP]),
        .rp         (status_q[B_RP1:B_RP0]),
        .dir_offset (dir_offset),
        .ind_ptr    (ind_ptr),
        .dir_addr   (dir_addr),
        .ind_addr   (ind_addr)
    );

endmodule

// File: rtl/proc_status_reg_chk.sv
module proc_status_reg_chk (
    input logic       clk,
    input logic       por,
    input logic       bus_we,
    input logic [7:0] bus_wdata,
    input logic       upd_z,
    input logic       val_z,
    input logic       upd_dc,
    input logic       val_dc,
    input logic       upd_c,
    input logic       val_c,
    input logic       ev_wdt_clr,
    input logic       ev_sleep,
    input logic       ev_wdt_trip,
    input logic [7:0] status_q
);

    logic any_upd;
    logic any_ev;
    assign any_upd = upd_z | upd_dc | upd_c;
    assign any_ev  = ev_wdt_clr | ev_sleep | ev_wdt_trip;

    a_r1_reset_value: assert property (@(posedge clk)
        por |=> (status_q == 8'b0001_1000));

    a_r2_bank_from_bus: assert property (@(posedge clk) disable iff (por)
        bus_we |=> (status_q[7:5] == $past(bus_wdata[7:5])));

    a_r2_flags_from_bus: assert property (@(posedge clk) disable iff (por)
        (bus_we && !any_upd) |=> (status_q[2:0] == $past(bus_wdata[2:0])));

    a_r2_pwr_bus_immune: assert property (@(posedge clk) disable iff (por)
        !any_ev |=> $stable(status_q[4:3]));

    a_r4_bus_masked_z: assert property (@(posedge clk) disable iff (por)
        (bus_we && any_upd) |=>
            (status_q[2] == ($past(upd_z) ? $past(val_z) : $past(status_q[2]))));

    a_r4_bus_masked_c: assert property (@(posedge clk) disable iff (por)
        (bus_we && any_upd) |=>
            (status_q[0] == ($past(upd_c) ? $past(val_c) : $past(status_q[0]))));

    a_r3_dc_update: assert property (@(posedge clk) disable iff (por)
        upd_dc |=> (status_q[1] == $past(val_dc)));

    a_r5_wdt_clear: assert property (@(posedge clk) disable iff (por)
        (ev_wdt_clr && !ev_sleep && !ev_wdt_trip) |=> (status_q[4:3] == 2'b11));

    a_r6_sleep: assert property (@(posedge clk) disable iff (por)
        (ev_sleep && !ev_wdt_trip) |=> (status_q[4:3] == 2'b10));

    a_r7_trip: assert property (@(posedge clk) disable iff (por)
        ev_wdt_trip |=> (!status_q[4] && (status_q[3] == $past(status_q[3]))));

endmodule

bind proc_status_reg proc_status_reg_chk chk_i (
    .clk         (clk),
    .por         (por),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .upd_z       (upd_z),
    .val_z       (val_z),
    .upd_dc      (upd_dc),
    .val_dc      (val_dc),
    .upd_c       (upd_c),
    .val_c       (val_c),
    .ev_wdt_clr  (ev_wdt_clr),
    .ev_sleep    (ev_sleep),
    .ev_wdt_trip (ev_wdt_trip),
    .status_q    (status_q)
);

// File: tb/proc_status_reg_tb_top.sv
module proc_status_reg_tb_top;

    localparam int OFF_W = 7;
    localparam int PTR_W = 8;

    logic             clk = 1'b0;
    logic             por = 1'b1;
    logic             bus_we = 1'b0;
    logic [7:0]       bus_wdata = '0;
    logic             upd_z = 1'b0, val_z = 1'b0;
    logic             upd_dc = 1'b0, val_dc = 1'b0;
    logic             upd_c = 1'b0, val_c = 1'b0;
    logic             ev_wdt_clr = 1'b0, ev_sleep = 1'b0, ev_wdt_trip = 1'b0;
    logic [OFF_W-1:0] dir_offset = '0;
    logic [PTR_W-1:0] ind_ptr = '0;
    logic [7:0]       status_q;
    logic [OFF_W+1:0] dir_addr;
    logic [PTR_W:0]   ind_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] exp_s;
    logic [31:0] lcg = 32'h1234_5678;

    always #10 clk = ~clk;

    proc_status_reg #(.OFF_W(OFF_W), .PTR_W(PTR_W)) dut_i (
        .clk(clk), .por(por), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .upd_z(upd_z), .val_z(val_z), .upd_dc(upd_dc), .val_dc(val_dc),
        .upd_c(upd_c), .val_c(val_c), .ev_wdt_clr(ev_wdt_clr),
        .ev_sleep(ev_sleep), .ev_wdt_trip(ev_wdt_trip),
        .dir_offset(dir_offset), .ind_ptr(ind_ptr), .status_q(status_q),
        .dir_addr(dir_addr), .ind_addr(ind_addr)
    );

    // Expected next word from the requirements; upd/val as {z,dc,c}, ev as {trip,sleep,clr}
    function automatic logic [7:0] model_next(input logic [7:0] s, input logic we,
                                              input logic [7:0] wd, input logic [2:0] upd,
                                              input logic [2:0] val, input logic [2:0] ev);
        logic [7:0] n;
        n = s;
        if (we) n[7:5] = wd[7:5];
        if (upd != 3'b000) begin
            for (int i = 0; i < 3; i++) if (upd[i]) n[i] = val[i];
        end else if (we) begin
            n[2:0] = wd[2:0];
        end
        if (ev[2])      n[4] = 1'b0;
        else if (ev[1]) n[4:3] = 2'b10;
        else if (ev[0]) n[4:3] = 2'b11;
        return n;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd(input logic [31:0] x);
        return x * 32'd1664525 + 32'd1013904223;
    endfunction

    // Called just after a falling edge; returns just after the next falling edge
    task automatic step(input string tag, input logic we, input logic [7:0] wd,
                        input logic [2:0] upd, input logic [2:0] val, input logic [2:0] ev);
        bus_we = we; bus_wdata = wd;
        {upd_z, upd_dc, upd_c} = upd;
        {val_z, val_dc, val_c} = val;
        {ev_wdt_trip, ev_sleep, ev_wdt_clr} = ev;
        @(posedge clk);
        @(negedge clk);
        exp_s = model_next(exp_s, we, wd, upd, val, ev);
        chk(tag, {24'd0, status_q}, {24'd0, exp_s});
    endtask

    function automatic string ev_tag(input logic we, input logic [2:0] ev);
        if ($countones(ev) > 1) return "R8";
        if (we && ev != 3'b000) return "R9";
        if (ev[2]) return "R7";
        if (ev[1]) return "R6";
        if (ev[0]) return "R5";
        return "R2";
    endfunction

    initial begin
        exp_s = 8'b0001_1000;
        @(negedge clk);
        @(negedge clk);
        por = 1'b0;
        chk("R1", {24'd0, status_q}, 32'h18);

        // R2: every bus word, no flag update, no event
        for (int d = 0; d < 256; d++) step("R2", 1'b1, d[7:0], 3'b000, 3'b000, 3'b000);

        // R3 / R4: all update enables and values, with and without bus write
        for (int u = 0; u < 8; u++) begin
            for (int v = 0; v < 8; v++) begin
                for (int w = 0; w < 2; w++) begin
                    lcg = rnd(lcg);
                    step((w == 1 && u != 0) ? "R4" : "R3", w[0], lcg[15:8],
                         u[2:0], v[2:0], 3'b000);
                end
            end
        end

        // R4: clear-to-zero with only Z updated to 1, from an all-ones word
        step("R2", 1'b1, 8'hFF, 3'b000, 3'b000, 3'b000);
        step("R4", 1'b1, 8'h00, 3'b100, 3'b100, 3'b000);
        chk("R4", {24'd0, status_q}, {24'd0, 8'b0001_1111});

        // R5..R9: every ordered pair of event sets, bus write toggled on the second
        for (int p = 0; p < 8; p++) begin
            for (int e = 0; e < 8; e++) begin
                for (int w = 0; w < 2; w++) begin
                    step(ev_tag(1'b0, p[2:0]), 1'b0, 8'h00, 3'b000, 3'b000, p[2:0]);
                    lcg = rnd(lcg);
                    step(ev_tag(w[0], e[2:0]), w[0], lcg[23:16], 3'b000, 3'b000, e[2:0]);
                end
            end
        end

        // R7: expiry leaves power-down held in both sleep and run
        step("R6", 1'b0, 8'h00, 3'b000, 3'b000, 3'b010);
        step("R7", 1'b0, 8'h00, 3'b000, 3'b000, 3'b100);
        chk("R7", {30'd0, status_q[4:3]}, 32'd0);

        // R10 / R11: all bank patterns, all offsets and pointers
        for (int b = 0; b < 8; b++) begin
            step("R2", 1'b1, {b[2:0], 5'b00000}, 3'b000, 3'b000, 3'b000);
            step("R2", 1'b0, 8'h00, 3'b000, 3'b000, 3'b000);
            for (int o = 0; o < 128; o++) begin
                dir_offset = o[OFF_W-1:0];
                #1;
                chk("R10", {23'd0, dir_addr}, exp_s[6:5] * 32'd128 + o);
            end
            for (int q = 0; q < 256; q++) begin
                ind_ptr = q[PTR_W-1:0];
                #1;
                chk("R11", {23'd0, ind_addr}, exp_s[7] * 32'd256 + q);
            end
            @(negedge clk);
        end

        // R1: reset from a non-initial word
        step("R2", 1'b1, 8'hE7, 3'b000, 3'b000, 3'b100);
        por = 1'b1;
        @(posedge clk);
        @(negedge clk);
        por = 1'b0;
        exp_s = 8'b0001_1000;
        chk("R1", {24'd0, status_q}, 32'h18);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule